// File: doc/BRIEF.md
# Extended Opcode Instruction Decoder

This block holds the opcode portion of the instruction that is currently executing and turns it into one-hot select lines, one per instruction. A 15-bit word is captured from the instruction buffer when the new-instruction strobe is high. The low twelve bits go to an address register. The top six bits go to an opcode register. Word bit n (numbered 15 down to 1) sits on `word_i[n-1]`.

A hidden extend flag acts as a fourth opcode bit and switches decoding to a second, extracode instruction set. The flag is a two-state machine. `ST_BASE` means the flag is clear and `ST_EXTRA` means it is set. It changes only on the single-cycle end-of-instruction pulse, and the change depends on the instruction held at that moment:

- `GO_EXTRA` (`ST_BASE` to `ST_EXTRA`) happens when the held instruction is the extend command.
- `KEEP` leaves the state as it is when the held instruction is an index form.
- `GO_BASE` (either state to `ST_BASE`) happens for every other instruction.

While the flag is set, interrupts are inhibited.

The meaning of the address field depends on the opcode. For the erasable-only classes, the top two address bits act as a quarter code that chooses among four instructions. For the channel class, bit 10 is an extra opcode bit. A jump whose address is exactly octal 6 decodes as the extend command. Decoding happens in two stages. The first stage expands the fields into one-hot lines. The second stage combines those lines with the flag to give one line per instruction.

Top module: `xop_decoder`

## Requirements
- R1: After reset, the opcode register, the address register and the extend flag are zero. This gives `addr_o`=0, `base_o`=1, `quarter_o`=1, `instr_o`=1 (JUMP), `ext_o`=0 and `irq_inhibit_o`=0.
- R2: When `new_instr_i` is high at a clock edge, `addr_o` shows word bits 12..1 (`word_i[11:0]`) after that edge. The opcode register takes word bits 15..10. While the strobe is low, both registers hold their values.
- R3: `base_o[k]` is high exactly when the held bits 15..13 equal k. `quarter_o[k]` is high exactly when the held bits 12..11 equal k.
- R4: With the flag clear, these opcodes (bits 15..13) decode without a quarter code: 3 selects LOADA (line 8), 4 selects LOADC (9), 6 selects ADD (14) and 7 selects MASK (15).
- R5: With the flag clear, these opcodes use the quarter code q:
  - Opcode 1 gives CSKIP (2) for q=0 and JUMPF (3) for any other q.
  - Opcode 2 gives line 4+q: DADD, LINK, INCR, ADDS.
  - Opcode 5 gives line 10+q: INDEX, DXCH, STORE, XCH.
- R6: With the flag clear, opcode 0 selects EXTEND (line 1) when the full 12-bit address equals octal 6. It selects JUMP (line 0) for any other address.
- R7: An end pulse that arrives while EXTEND is selected sets the flag from the next cycle on. `ext_o` shows the flag.
- R8: With the flag set, the opcodes decode as follows:
  - Opcode 1 gives DIV (18) for q=0 and BRZ (19) otherwise.
  - Opcode 2 gives line 20+q: MSUB, QXCH, AUG, DIM.
  - Opcode 3 gives DLOADA (24) and opcode 4 gives DLOADC (25).
  - Opcode 5 gives XINDEX (26) for q=0, SUB (27) for q=1 and BRNEG (28) for q=2 or 3.
  - Opcode 6 gives BRNEG (28) and opcode 7 gives MUL (29).
- R9: With the flag set, opcode 0 is the channel class. Bit 10 chooses CHIN (16) when 0 and CHOUT (17) when 1, and the address and quarter code play no part.
- R10: An end pulse clears the flag unless the held instruction is INDEX (10) or XINDEX (26). Those two leave the flag unchanged.
- R11: `irq_inhibit_o` is high exactly while the flag is set.
- R12: Exactly one bit of `instr_o` is high in every cycle after reset.
- R13: Without an end pulse the flag does not change. When a load and an end pulse fall in the same cycle, the flag update uses the instruction held before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| new_instr_i | input | 1 | Load strobe for the instruction word |
| end_instr_i | input | 1 | Single-cycle end-of-instruction pulse |
| word_i | input | 15 | Instruction word from the buffer register |
| addr_o | output | 12 | Held address field, bits 12..1 |
| base_o | output | 8 | One-hot base opcode lines |
| quarter_o | output | 4 | One-hot quarter-code lines |
| instr_o | output | 30 | One-hot instruction select, one line per instruction |
| ext_o | output | 1 | Extend flag |
| irq_inhibit_o | output | 1 | Interrupt inhibit |

## Verification
A wrong flag state is visible at the ports in the cycle after the end pulse that caused it. The selected line then moves from one instruction set to the other, and `ext_o` and `irq_inhibit_o` change with it. A fault in the opcode or address register shows as a wrong base, quarter or select line in the cycle after the load. The sweep drives every combination of the six opcode bits against address patterns that include octal 6 and patterns close to it, in both states. It also covers loads that coincide with end pulses and end pulses on index forms.

// File: rtl/xop_pkg.sv
package xop_pkg;
    localparam int WORD_W    = 15;
    localparam int ADDR_W    = 12;
    localparam int OPC_LSB   = 9;                 // word bit 10
    localparam int OPC_W     = WORD_W - OPC_LSB;  // bits 15..10
    localparam int BASE_W    = 3;
    localparam int QTR_W     = 2;
    localparam int BASE_N    = 1 << BASE_W;
    localparam int QTR_N     = 1 << QTR_W;
    localparam int NUM_INSTR = 30;

    typedef enum logic [4:0] {
        I_JUMP   = 5'd0,  I_EXTEND = 5'd1,  I_CSKIP  = 5'd2,  I_JUMPF  = 5'd3,
        I_DADD   = 5'd4,  I_LINK   = 5'd5,  I_INCR   = 5'd6,  I_ADDS   = 5'd7,
        I_LOADA  = 5'd8,  I_LOADC  = 5'd9,  I_INDEX  = 5'd10, I_DXCH   = 5'd11,
        I_STORE  = 5'd12, I_XCH    = 5'd13, I_ADD    = 5'd14, I_MASK   = 5'd15,
        I_CHIN   = 5'd16, I_CHOUT  = 5'd17, I_DIV    = 5'd18, I_BRZ    = 5'd19,
        I_MSUB   = 5'd20, I_QXCH   = 5'd21, I_AUG    = 5'd22, I_DIM    = 5'd23,
        I_DLOADA = 5'd24, I_DLOADC = 5'd25, I_XINDEX = 5'd26, I_SUB    = 5'd27,
        I_BRNEG  = 5'd28, I_MUL    = 5'd29
    } instr_e;

    typedef enum logic {
        ST_BASE  = 1'b0,
        ST_EXTRA = 1'b1
    } ext_state_e;
endpackage

// File: rtl/xop_field_reg.sv
module xop_field_reg
    import xop_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [WORD_W-1:0]   word_i,
    output logic [OPC_W-1:0]    opc_o,
    output logic [ADDR_W-1:0]   addr_o
);
    logic [OPC_W-1:0]  opc_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opc_q  <= '0;
            addr_q <= '0;
        end else if (load_i) begin
            opc_q  <= word_i[WORD_W-1:OPC_LSB];
            addr_q <= word_i[ADDR_W-1:0];
        end
    end

    assign opc_o  = opc_q;
    assign addr_o = addr_q;

    a_r2_opc_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (opc_o == $past(word_i[WORD_W-1:OPC_LSB])));
    a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(addr_o));
endmodule

// File: rtl/xop_stage1.sv
module xop_stage1
    import xop_pkg::*;
(
    input  logic [OPC_W-1:0]  opc_i,
    output logic [BASE_N-1:0] base_o,
    output logic [QTR_N-1:0]  qtr_o
);
    logic [BASE_W-1:0] base_f;
    logic [QTR_W-1:0]  qtr_f;

    assign base_f = opc_i[OPC_W-1 -: BASE_W];
    assign qtr_f  = opc_i[OPC_W-BASE_W-1 -: QTR_W];

    for (genvar k = 0; k < BASE_N; k++) begin : g_base
        assign base_o[k] = (base_f == BASE_W'(k));
    end
    for (genvar k = 0; k < QTR_N; k++) begin : g_qtr
        assign qtr_o[k] = (qtr_f == QTR_W'(k));
    end
endmodule

// File: rtl/xop_stage2.sv
module xop_stage2
    import xop_pkg::*;
#(
    parameter logic [ADDR_W-1:0] EXT_ADDR = ADDR_W'(6)
) (
    input  logic [BASE_N-1:0]    base_i,
    input  logic [QTR_N-1:0]     qtr_i,
    input  logic                 chan_i,
    input  logic                 ext_i,
    input  logic [ADDR_W-1:0]    addr_i,
    output logic [NUM_INSTR-1:0] sel_o,
    output logic                 is_extend_o,
    output logic                 is_index_o
);
    logic at_ext;
    logic bs;
    logic xs;

    assign at_ext = (addr_i == EXT_ADDR);
    assign bs     = ~ext_i;
    assign xs     = ext_i;

    always_comb begin
        sel_o = '0;
        // base set
        sel_o[I_JUMP]   = bs & base_i[0] & ~at_ext;
        sel_o[I_EXTEND] = bs & base_i[0] &  at_ext;
        sel_o[I_CSKIP]  = bs & base_i[1] &  qtr_i[0];
        sel_o[I_JUMPF]  = bs & base_i[1] & ~qtr_i[0];
        for (int k = 0; k < QTR_N; k++) begin
            sel_o[int'(I_DADD) + k]  = bs & base_i[2] & qtr_i[k];
            sel_o[int'(I_INDEX) + k] = bs & base_i[5] & qtr_i[k];
            sel_o[int'(I_MSUB) + k]  = xs & base_i[2] & qtr_i[k];
        end
        sel_o[I_LOADA]  = bs & base_i[3];
        sel_o[I_LOADC]  = bs & base_i[4];
        sel_o[I_ADD]    = bs & base_i[6];
        sel_o[I_MASK]   = bs & base_i[7];
        // extracode set
        sel_o[I_CHIN]   = xs & base_i[0] & ~chan_i;
        sel_o[I_CHOUT]  = xs & base_i[0] &  chan_i;
        sel_o[I_DIV]    = xs & base_i[1] &  qtr_i[0];
        sel_o[I_BRZ]    = xs & base_i[1] & ~qtr_i[0];
        sel_o[I_DLOADA] = xs & base_i[3];
        sel_o[I_DLOADC] = xs & base_i[4];
        sel_o[I_XINDEX] = xs & base_i[5] & qtr_i[0];
        sel_o[I_SUB]    = xs & base_i[5] & qtr_i[1];
        sel_o[I_BRNEG]  = xs & ((base_i[5] & (qtr_i[2] | qtr_i[3])) | base_i[6]);
        sel_o[I_MUL]    = xs & base_i[7];
    end

    assign is_extend_o = sel_o[I_EXTEND];
    assign is_index_o  = sel_o[I_INDEX] | sel_o[I_XINDEX];
endmodule

// File: rtl/xop_ext_fsm.sv
module xop_ext_fsm
    import xop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic end_i,
    input  logic is_extend_i,
    input  logic is_index_i,
    output logic ext_o,
    output logic inhibit_o
);
    ext_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (end_i) begin
            unique case (state_q)
                ST_BASE: begin
                    if (is_extend_i)     state_d = ST_EXTRA;  // GO_EXTRA
                    else if (is_index_i) state_d = ST_BASE;   // KEEP
                    else                 state_d = ST_BASE;   // GO_BASE
                end
                ST_EXTRA: begin
                    if (is_index_i)      state_d = ST_EXTRA;  // KEEP
                    else                 state_d = ST_BASE;   // GO_BASE
                end
                default:                 state_d = ST_BASE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BASE;
        else        state_q <= state_d;
    end

    always_comb begin
        ext_o     = (state_q == ST_EXTRA);
        inhibit_o = (state_q == ST_EXTRA);
    end

    a_r7_set_on_extend: assert property (@(posedge clk) disable iff (!rst_n)
        (end_i && is_extend_i) |=> ext_o);
    a_r10_clear_on_end: assert property (@(posedge clk) disable iff (!rst_n)
        (end_i && !is_extend_i && !is_index_i) |=> !ext_o);
    a_r10_index_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (end_i && is_index_i) |=> $stable(ext_o));
    a_r13_no_end_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !end_i |=> $stable(ext_o));
endmodule

// File: rtl/xop_decoder.sv
module xop_decoder
    import xop_pkg::*;
#(
    parameter logic [ADDR_W-1:0] EXT_ADDR = ADDR_W'(6)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 new_instr_i,
    input  logic                 end_instr_i,
    input  logic [WORD_W-1:0]    word_i,
    output logic [ADDR_W-1:0]    addr_o,
    output logic [BASE_N-1:0]    base_o,
    output logic [QTR_N-1:0]     quarter_o,
    output logic [NUM_INSTR-1:0] instr_o,
    output logic                 ext_o,
    output logic                 irq_inhibit_o
);
    logic [OPC_W-1:0] opc;
    logic             is_extend;
    logic             is_index;

    xop_field_reg u_field (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (new_instr_i),
        .word_i (word_i),
        .opc_o  (opc),
        .addr_o (addr_o)
    );

    xop_stage1 u_stage1 (
        .opc_i  (opc),
        .base_o (base_o),
        .qtr_o  (quarter_o)
    );

    xop_stage2 #(.EXT_ADDR(EXT_ADDR)) u_stage2 (
        .base_i      (base_o),
        .qtr_i       (quarter_o),
        .chan_i      (opc[0]),
        .ext_i       (ext_o),
        .addr_i      (addr_o),
        .sel_o       (instr_o),
        .is_extend_o (is_extend),
        .is_index_o  (is_index)
    );

    xop_ext_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .end_i       (end_instr_i),
        .is_extend_i (is_extend),
        .is_index_i  (is_index),
        .ext_o       (ext_o),
        .inhibit_o   (irq_inhibit_o)
    );

    a_r12_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(instr_o));
    a_r3_base_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(base_o) && $onehot(quarter_o));
    a_r6_extend_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (base_o[0] && !ext_o && addr_o == EXT_ADDR) |-> instr_o[I_EXTEND]);
    a_r9_channel_set: assert property (@(posedge clk) disable iff (!rst_n)
        (base_o[0] && ext_o) |-> (instr_o[I_CHIN] || instr_o[I_CHOUT]));
endmodule

// File: tb/xop_decoder_tb_top.sv
`timescale 1ns/100ps
module xop_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        new_instr_i = 1'b0;
    logic        end_instr_i = 1'b0;
    logic [14:0] word_i = '0;
    logic [11:0] addr_o;
    logic [7:0]  base_o;
    logic [3:0]  quarter_o;
    logic [29:0] instr_o;
    logic        ext_o;
    logic        irq_inhibit_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    xop_decoder dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .new_instr_i   (new_instr_i),
        .end_instr_i   (end_instr_i),
        .word_i        (word_i),
        .addr_o        (addr_o),
        .base_o        (base_o),
        .quarter_o     (quarter_o),
        .instr_o       (instr_o),
        .ext_o         (ext_o),
        .irq_inhibit_o (irq_inhibit_o)
    );

    function automatic int exp_idx(bit ext, logic [14:0] w);
        int o = int'(w[14:12]);
        int q = int'(w[11:10]);
        if (!ext) begin
            case (o)
                0: return (w[11:0] == 12'o0006) ? 1 : 0;
                1: return (q == 0) ? 2 : 3;
                2: return 4 + q;
                3: return 8;
                4: return 9;
                5: return 10 + q;
                6: return 14;
                default: return 15;
            endcase
        end else begin
            case (o)
                0: return w[9] ? 17 : 16;
                1: return (q == 0) ? 18 : 19;
                2: return 20 + q;
                3: return 24;
                4: return 25;
                5: return (q == 0) ? 26 : ((q == 1) ? 27 : 28);
                6: return 28;
                default: return 29;
            endcase
        end
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(bit n, bit e, logic [14:0] w);
        new_instr_i = n;
        end_instr_i = e;
        word_i      = w;
        @(negedge clk);
        new_instr_i = 1'b0;
        end_instr_i = 1'b0;
    endtask

    task automatic clear_flag();
        cyc(1'b1, 1'b1, 15'o00000);
        cyc(1'b1, 1'b1, 15'o00000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [8:0] lows [6];
        lows[0] = 9'h000; lows[1] = 9'h006; lows[2] = 9'h007;
        lows[3] = 9'h001; lows[4] = 9'h1FF; lows[5] = 9'h106;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 addr", 32'(addr_o), 32'h0);
        check("R1 base", 32'(base_o), 32'h1);
        check("R1 quarter", 32'(quarter_o), 32'h1);
        check("R1 instr", 32'(instr_o), 32'h1);
        check("R1 ext", 32'(ext_o), 32'h0);
        check("R1 inhibit", 32'(irq_inhibit_o), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int t = 0; t < 64; t++) begin
            for (int p = 0; p < 6; p++) begin
                logic [14:0] w;
                int bi, xi;
                w  = {6'(t), lows[p]};
                bi = exp_idx(1'b0, w);
                xi = exp_idx(1'b1, w);

                // base set
                clear_flag();
                cyc(1'b1, 1'b0, w);
                check("R2 addr", 32'(addr_o), 32'(w[11:0]));
                check("R3 base", 32'(base_o), 32'(8'(1) << w[14:12]));
                check("R3 quarter", 32'(quarter_o), 32'(4'(1) << w[11:10]));
                check("R4/R5/R6 base decode", 32'(instr_o), 32'(30'(1) << bi));
                check("R12 one select", 32'($countones(instr_o)), 32'd1);
                check("R11 inhibit base", 32'(irq_inhibit_o), 32'h0);
                cyc(1'b0, 1'b1, 15'o0);
                check("R7/R10 flag after base end", 32'(ext_o), 32'(bi == 1));
                check("R2 addr hold", 32'(addr_o), 32'(w[11:0]));

                // extracode set, load coinciding with end of EXTEND
                clear_flag();
                cyc(1'b1, 1'b0, 15'o00006);
                cyc(1'b1, 1'b1, w);
                check("R7/R13 flag set", 32'(ext_o), 32'h1);
                check("R11 inhibit set", 32'(irq_inhibit_o), 32'h1);
                check("R8/R9 extra decode", 32'(instr_o), 32'(30'(1) << xi));
                check("R3 base extra", 32'(base_o), 32'(8'(1) << w[14:12]));
                cyc(1'b0, 1'b0, ~w);
                cyc(1'b0, 1'b0, ~w);
                check("R13 flag stable", 32'(ext_o), 32'h1);
                check("R2 addr stable", 32'(addr_o), 32'(w[11:0]));
                check("R12 extra select", 32'($countones(instr_o)), 32'd1);
                cyc(1'b0, 1'b1, 15'o0);
                check("R10 flag after extra end", 32'(ext_o), 32'(xi == 26));
                check("R11 inhibit follows", 32'(irq_inhibit_o), 32'(xi == 26));
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule